// File: doc/BRIEF.md
# Dual-Port Shared Mailbox Memory

This block is a word-addressed store shared by two independent processors, A and B. Each processor has its own port carrying a request, a write enable, an address and write data, and each port returns an acknowledge and read data. The processors talk to each other only through this storage. The array is split into two halves of equal size. The lower half carries messages from B to A, and the upper half carries messages from A to B. The first word of each half is that mailbox's command word, and the payload follows from the second word of the half.

The same single array serves both ports, so one access is carried out per clock. Port A belongs to the time-critical processor and wins every cycle in which it requests. A request from port B is held off, with its acknowledge low, until a cycle in which A is idle. The block raises no interrupt. Two status outputs show whether each command word is non-zero, and a processor learns about pending work either from these outputs or by reading the command word. The whole array is cleared on reset, so both mailboxes start empty.

Handshake: a port presents a request in a cycle by holding `req` high at the clock edge. If that request is granted, `ack` is high during the following cycle and `rdata` carries the result. A port whose request is not granted keeps its request unchanged. In the cycle in which `ack` is high, the value on `req` already stands for the next transaction.

Top module: `mbx_shared_mem`

## Requirements
- R1: While reset is high and in the first cycle after it, both acknowledges are low, both read-data outputs are zero and both pending flags are low. Every word of the array reads zero after reset.
- R2: When `a_req` is high at a clock edge, `a_ack` is high in the next cycle, whatever port B is doing. When `a_req` is low, `a_ack` is low in the next cycle.
- R3: When `b_req` is high and `a_req` is low at a clock edge, `b_ack` is high in the next cycle.
- R4: When `a_req` and `b_req` are both high at a clock edge, `b_ack` is low in the next cycle. The waiting B request is served at the first edge at which `a_req` is low.
- R5: `a_ack` and `b_ack` are never high in the same cycle.
- R6: In an acknowledge cycle, `rdata` holds the content the addressed word had before the access. For a write, the word takes the value of `wdata`. Between acknowledges, a port's `rdata` keeps its last value.
- R7: Both ports see one storage array, so a word written through one port reads back the same value through the other port.
- R8: `mbx_ba_pending` is high exactly when word 0 (the command word of the B-to-A mailbox) is non-zero. It follows a write to that word from the cycle after the write edge.
- R9: `mbx_ab_pending` is high exactly when word DEPTH/2 (address 1024 by default, the command word of the A-to-B mailbox) is non-zero. It follows a write to that word from the cycle after the write edge.
- R10: When both ports write the same address at the same edge, port A's data is stored at that edge. A read by A at the next edge returns A's data. B's held write lands only at the first later edge at which A is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears the array |
| a_req | input | 1 | Port A request (priority port) |
| a_we | input | 1 | Port A write enable |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_ack | output | 1 | Port A acknowledge, one cycle after the request |
| a_rdata | output | DATA_W | Port A read data, valid with `a_ack` |
| b_req | input | 1 | Port B request |
| b_we | input | 1 | Port B write enable |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_ack | output | 1 | Port B acknowledge, delayed while A is active |
| b_rdata | output | DATA_W | Port B read data, valid with `b_ack` |
| mbx_ab_pending | output | 1 | A-to-B command word is non-zero |
| mbx_ba_pending | output | 1 | B-to-A command word is non-zero |

## Verification
Two functions can fall in the same cycle: a request on port A and a request on port B, which may even be writes to the same word or to a command word. Random traffic is confined to a handful of addresses, including both command words, so that collisions and flag changes happen often. A directed sequence makes both ports write one address at the same edge and then reads it back from A before and after B's delayed write. Every cycle, the acknowledges, both read-data outputs and both flags are compared against a bench model that serves A first and holds B until A is idle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [1:0] {
        GNT_NONE = 2'b00,
        GNT_A    = 2'b01,
        GNT_B    = 2'b10
    } grant_e;

    // Word index of a mailbox command word: lower half is B->A, upper half is A->B.
    function automatic int unsigned cmd_index(input bit upper_half, input int unsigned depth);
        return upper_half ? (depth / 2) : 0;
    endfunction

endpackage

// File: rtl/mbx_arbiter.sv
module mbx_arbiter
    import mbx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   a_req,
    input  logic   b_req,
    output grant_e gnt,
    output logic   a_ack,
    output logic   b_ack
);

    // Port A is never refused; port B only gets the cycles A leaves free.
    always_comb begin
        if (a_req)      gnt = GNT_A;
        else if (b_req) gnt = GNT_B;
        else            gnt = GNT_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_ack <= 1'b0;
            b_ack <= 1'b0;
        end else begin
            a_ack <= (gnt == GNT_A);
            b_ack <= (gnt == GNT_B);
        end
    end

endmodule

// File: rtl/mbx_store.sv
module mbx_store
    import mbx_pkg::*;
#(
    parameter int DEPTH  = 2048,
    parameter int DATA_W = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  grant_e            gnt,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic [DATA_W-1:0] cmd_ba,
    output logic [DATA_W-1:0] cmd_ab
);

    localparam int unsigned BA_IDX = cmd_index(1'b0, DEPTH);
    localparam int unsigned AB_IDX = cmd_index(1'b1, DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];

    logic              sel_we;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_wdata;

    always_comb begin
        sel_we    = 1'b0;
        sel_addr  = a_addr;
        sel_wdata = a_wdata;
        unique case (gnt)
            GNT_A: begin
                sel_we = a_we;
            end
            GNT_B: begin
                sel_we    = b_we;
                sel_addr  = b_addr;
                sel_wdata = b_wdata;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
            a_rdata <= '0;
            b_rdata <= '0;
        end else begin
            if (gnt == GNT_A) a_rdata <= mem[sel_addr];
            if (gnt == GNT_B) b_rdata <= mem[sel_addr];
            if (sel_we) mem[sel_addr] <= sel_wdata;
        end
    end

    assign cmd_ba = mem[BA_IDX];
    assign cmd_ab = mem[AB_IDX];

endmodule

// File: rtl/mbx_flags.sv
module mbx_flags #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] cmd_ba,
    input  logic [DATA_W-1:0] cmd_ab,
    output logic              ba_pending,
    output logic              ab_pending
);

    assign ba_pending = |cmd_ba;
    assign ab_pending = |cmd_ab;

endmodule

// File: rtl/mbx_shared_mem.sv
module mbx_shared_mem
    import mbx_pkg::*;
#(
    parameter int DEPTH  = 2048,
    parameter int DATA_W = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_req,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic              a_ack,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_req,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic              b_ack,
    output logic [DATA_W-1:0] b_rdata,
    output logic              mbx_ab_pending,
    output logic              mbx_ba_pending
);

    grant_e            gnt;
    logic [DATA_W-1:0] cmd_ba;
    logic [DATA_W-1:0] cmd_ab;

    mbx_arbiter u_arb (
        .clk   (clk),
        .rst   (rst),
        .a_req (a_req),
        .b_req (b_req),
        .gnt   (gnt),
        .a_ack (a_ack),
        .b_ack (b_ack)
    );

    mbx_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .gnt     (gnt),
        .a_we    (a_we),
        .a_addr  (a_addr),
        .a_wdata (a_wdata),
        .b_we    (b_we),
        .b_addr  (b_addr),
        .b_wdata (b_wdata),
        .a_rdata (a_rdata),
        .b_rdata (b_rdata),
        .cmd_ba  (cmd_ba),
        .cmd_ab  (cmd_ab)
    );

    mbx_flags #(.DATA_W(DATA_W)) u_flags (
        .cmd_ba     (cmd_ba),
        .cmd_ab     (cmd_ab),
        .ba_pending (mbx_ba_pending),
        .ab_pending (mbx_ab_pending)
    );

endmodule

// File: rtl/mbx_shared_mem_chk.sv
module mbx_shared_mem_chk #(
    parameter int DEPTH  = 2048,
    parameter int DATA_W = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst,
    input logic              a_req,
    input logic              a_we,
    input logic [ADDR_W-1:0] a_addr,
    input logic [DATA_W-1:0] a_wdata,
    input logic              a_ack,
    input logic              b_req,
    input logic              b_we,
    input logic [ADDR_W-1:0] b_addr,
    input logic [DATA_W-1:0] b_wdata,
    input logic              b_ack,
    input logic              mbx_ab_pending,
    input logic              mbx_ba_pending
);

    localparam logic [ADDR_W-1:0] BA_ADDR = '0;
    localparam logic [ADDR_W-1:0] AB_ADDR = ADDR_W'(DEPTH / 2);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!a_ack && !b_ack && !mbx_ab_pending && !mbx_ba_pending));

    assert_a_served_R2: assert property (@(posedge clk) disable iff (rst)
        a_req |=> a_ack);

    assert_a_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
        !a_req |=> !a_ack);

    assert_b_alone_R3: assert property (@(posedge clk) disable iff (rst)
        (b_req && !a_req) |=> b_ack);

    assert_b_held_R4: assert property (@(posedge clk) disable iff (rst)
        (a_req && b_req) |=> !b_ack);

    assert_single_ack_R5: assert property (@(posedge clk) disable iff (rst)
        !(a_ack && b_ack));

    assert_ba_set_by_b_R8: assert property (@(posedge clk) disable iff (rst)
        (b_req && !a_req && b_we && b_addr == BA_ADDR && b_wdata != '0) |=> mbx_ba_pending);

    assert_ba_clear_by_a_R8: assert property (@(posedge clk) disable iff (rst)
        (a_req && a_we && a_addr == BA_ADDR && a_wdata == '0) |=> !mbx_ba_pending);

    assert_ab_set_by_a_R9: assert property (@(posedge clk) disable iff (rst)
        (a_req && a_we && a_addr == AB_ADDR && a_wdata != '0) |=> mbx_ab_pending);

    assert_ab_clear_by_b_R9: assert property (@(posedge clk) disable iff (rst)
        (b_req && !a_req && b_we && b_addr == AB_ADDR && b_wdata == '0) |=> !mbx_ab_pending);

endmodule

bind mbx_shared_mem mbx_shared_mem_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .a_req          (a_req),
    .a_we           (a_we),
    .a_addr         (a_addr),
    .a_wdata        (a_wdata),
    .a_ack          (a_ack),
    .b_req          (b_req),
    .b_we           (b_we),
    .b_addr         (b_addr),
    .b_wdata        (b_wdata),
    .b_ack          (b_ack),
    .mbx_ab_pending (mbx_ab_pending),
    .mbx_ba_pending (mbx_ba_pending)
);

// File: tb/tb_mbx_shared_mem.sv
module tb_mbx_shared_mem;

    localparam int DEPTH  = 2048;
    localparam int DATA_W = 16;
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int HALF   = DEPTH / 2;
    localparam int WATCHDOG_CYCLES = 100000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              a_req = 1'b0, a_we = 1'b0;
    logic [ADDR_W-1:0] a_addr = '0;
    logic [DATA_W-1:0] a_wdata = '0;
    logic              b_req = 1'b0, b_we = 1'b0;
    logic [ADDR_W-1:0] b_addr = '0;
    logic [DATA_W-1:0] b_wdata = '0;
    logic              a_ack, b_ack;
    logic [DATA_W-1:0] a_rdata, b_rdata;
    logic              mbx_ab_pending, mbx_ba_pending;

    mbx_shared_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst(rst),
        .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_ack(a_ack), .a_rdata(a_rdata),
        .b_req(b_req), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_ack(b_ack), .b_rdata(b_rdata),
        .mbx_ab_pending(mbx_ab_pending), .mbx_ba_pending(mbx_ba_pending)
    );

    always #10 clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 0;

    // Bench model
    logic [DATA_W-1:0] model [DEPTH];
    logic              exp_a_ack = 0, exp_b_ack = 0;
    logic [DATA_W-1:0] exp_a_rd = '0, exp_b_rd = '0;
    string             b_tag = "R3";
    bit                b_wait = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_ba();
        return model[0] != '0;
    endfunction

    function automatic logic exp_ab();
        return model[HALF] != '0;
    endfunction

    // One cycle: check the outputs produced by the last edge, then drive
    // the next inputs and predict what the coming edge will do.
    task automatic step(input bit ar, input bit aw, input int aa, input int ad,
                        input bit bn, input bit bw, input int ba, input int bd);
        @(negedge clk);
        chk("R2", a_ack, exp_a_ack);
        chk(b_tag, b_ack, exp_b_ack);
        chk("R5", a_ack && b_ack, 0);
        chk("R6", a_rdata, exp_a_rd);
        chk("R6", b_rdata, exp_b_rd);
        chk("R8", mbx_ba_pending, exp_ba());
        chk("R9", mbx_ab_pending, exp_ab());
        a_req = ar; a_we = aw; a_addr = ADDR_W'(aa); a_wdata = DATA_W'(ad);
        if (!b_wait) begin
            b_req = bn; b_we = bw; b_addr = ADDR_W'(ba); b_wdata = DATA_W'(bd);
        end
        exp_a_ack = a_req;
        exp_b_ack = b_req && !a_req;
        b_tag     = (a_req && b_req) ? "R4" : "R3";
        if (a_req) begin
            exp_a_rd = model[a_addr];
            if (a_we) model[a_addr] = a_wdata;
        end else if (b_req) begin
            exp_b_rd = model[b_addr];
            if (b_we) model[b_addr] = b_wdata;
        end
        b_wait = b_req && a_req;
    endtask

    function automatic int pick_addr();
        case ($urandom % 6)
            0: return 0;
            1: return 1;
            2: return HALF;
            3: return HALF + 1;
            4: return 2;
            default: return $urandom % DEPTH;
        endcase
    endfunction

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG_CYCLES) begin
                n_checks++;
                n_fails++;
                $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG_CYCLES);
                $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
                $finish;
            end
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        rst = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1", a_ack, 0);
        chk("R1", b_ack, 0);
        chk("R1", a_rdata, 0);
        chk("R1", b_rdata, 0);
        chk("R1", {mbx_ab_pending, mbx_ba_pending}, 0);
        rst = 1'b0;

        // R1: array is clear after reset (sample words across the range)
        step(1, 0, DEPTH - 1, 0, 1, 0, 0, 0);
        step(1, 0, HALF, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 777, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        chk("R1", a_rdata, 0);
        chk("R1", b_rdata, 0);

        // R10: same-address write collision
        step(1, 1, 5, 16'h1111, 1, 1, 5, 16'h2222);
        step(1, 0, 5, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        chk("R10", a_rdata, 16'h1111);
        chk("R10", b_ack, 0);
        step(1, 0, 5, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        chk("R10", a_rdata, 16'h2222);

        // R7: cross-port visibility
        step(1, 1, 7, 16'hABCD, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 7, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        chk("R7", b_rdata, 16'hABCD);

        // R8 / R9: command words drive the pending flags
        step(0, 0, 0, 0, 1, 1, 0, 16'h0042);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        chk("R8", mbx_ba_pending, 1);
        step(1, 1, 0, 0, 0, 0, 0, 0);
        step(1, 1, HALF, 16'h8000, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        chk("R8", mbx_ba_pending, 0);
        chk("R9", mbx_ab_pending, 1);
        step(0, 0, 0, 0, 1, 1, HALF, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        chk("R9", mbx_ab_pending, 0);

        // R4: B starved by continuous A traffic, then served
        step(1, 0, 1, 0, 1, 1, 9, 16'h0909);
        for (int i = 0; i < 5; i++) step(1, 0, 2, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        chk("R4", b_ack, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        chk("R4", b_ack, 1);

        // Random mixed traffic
        for (int n = 0; n < 4000; n++) begin
            step(($urandom % 100) < 55, $urandom % 2, pick_addr(), $urandom % 4,
                 ($urandom % 100) < 60, $urandom % 2, pick_addr(), $urandom % 4);
        end
        for (int n = 0; n < 4; n++) step(0, 0, 0, 0, 0, 0, 0, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule